// File: doc/BRIEF.md
# Key-Gated Serial Register Port

This block guards a hidden timekeeping register on a memory-style bus that has an active-low chip enable, output enable, write enable, an address bus and a single data bit. The register stays out of reach until the bus master has issued a run of `SEQ_W` write cycles whose data bits spell out a fixed key, one bit per cycle, least significant bit first. A read cycle at any point during that run sends recognition back to the first key bit. A single wrong bit makes the block ignore every later write until a read arrives.

When the whole key has matched, the port opens for `SEQ_W` more bus cycles. Each of these cycles moves one register bit, in index order from 0. Each cycle can carry data either way: a write hands a bit to the register through a one-cycle store strobe, and a read drives the indexed register bit onto the data output. After the last transfer cycle the port locks again. The input `mode_rom_i` selects between two variants. In the RAM-style variant the write-enable pin picks the direction and the data bit arrives on the data input. In the ROM-style variant address bit 2 picks the direction (low means write) and address bit 0 carries the incoming bit. Cycles whose address falls outside the block's region are ignored, so other bus traffic can be interleaved at will.

A bus cycle counts when chip enable deasserts, as seen on a rising clock edge. The control inputs are expected to be synchronous to `clk_i`. Because the state at power-up is unknown, `SEQ_W` consecutive in-region reads always bring the port back to a locked state with recognition at key bit 0.

Top module: `serial_key_port`

## Requirements
- R1: After reset the port is locked, recognition waits for key bit 0, `dq0_oe_o` is 0 and `tk_we_o` is 0.
- R2: `SEQ_W` consecutive in-region write cycles whose data bits equal `KEY[0]`, `KEY[1]`, and so on in that order unlock the port.
- R3: After a write whose bit differs from the expected key bit, all later writes are ignored for recognition until the next in-region read, so the port stays locked even if the remaining or complete key follows.
- R4: An in-region read while locked restarts recognition at key bit 0. Bits sent before the read do not count toward the key.
- R5: While unlocked, the k-th in-region cycle (k counted from 0) transfers register bit k. A write cycle pulses `tk_we_o` for one clock, with `tk_idx_o` = k and `tk_d_o` = the incoming bit, on the clock after chip enable deasserts.
- R6: During an unlocked read cycle, `dq0_oe_o` is 1 and `dq0_o` equals `tk_q_i[k]`, but only while both `ce_ni` and `oe_ni` are low. A read with `oe_ni` high still consumes its index.
- R7: After `SEQ_W` transfer cycles the port locks again with recognition at key bit 0, so a fresh unlock is needed.
- R8: Cycles whose address does not satisfy `(addr_i & REGION_MASK) == REGION_BASE` have no effect on recognition, transfer progress, `tk_we_o` or `dq0_oe_o`.
- R9: With `mode_rom_i` = 0, a cycle is a write when `we_ni` is low and a read otherwise, and the incoming bit is `dq0_i`. Address bits inside the region do not matter.
- R10: With `mode_rom_i` = 1, a cycle is a write when address bit 2 is 0 and a read when it is 1, the incoming bit is address bit 0, and `we_ni` and `dq0_i` are ignored.
- R11: From any state, `SEQ_W` consecutive in-region reads leave the port locked with recognition at key bit 0.
- R12: `dq0_oe_o` stays 0 whenever the port is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_rom_i | input | 1 | 0: RAM-style variant, 1: ROM-style variant |
| ce_ni | input | 1 | Chip enable, active low; a cycle counts on its deassertion |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low (RAM-style only) |
| addr_i | input | ADDR_W | Bus address |
| dq0_i | input | 1 | Incoming data bit (RAM-style) |
| dq0_o | output | 1 | Outgoing register bit |
| dq0_oe_o | output | 1 | Drive enable for `dq0_o` |
| tk_q_i | input | SEQ_W | Current contents of the timekeeping register |
| tk_we_o | output | 1 | One-cycle store strobe for a received bit |
| tk_idx_o | output | $clog2(SEQ_W) | Index of the bit being stored |
| tk_d_o | output | 1 | Value of the bit being stored |

## Verification
The bench builds the block with `SEQ_W` = 16, a 6-bit address and a region of eight addresses, and runs every scenario in both variants. The short key makes it practical to sweep the mismatch position across every key bit, and a full transfer pass covers every register index. With a small address space, foreign cycles can be interleaved during both recognition and transfer. Resynchronisation is checked from the middle of a transfer.

// File: rtl/skp_pkg.sv
package skp_pkg;
  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_DEAF = 2'd1,
    PH_XFER = 2'd2
  } phase_e;

  typedef struct packed {
    logic valid;
    logic wr;
    logic bit_v;
  } bus_evt_t;
endpackage

// File: rtl/skp_bus_sampler.sv
module skp_bus_sampler
  import skp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_rom_i,
  input  logic     ce_ni,
  input  logic     we_ni,
  input  logic     hit_i,
  input  logic     a2_i,
  input  logic     a0_i,
  input  logic     dq0_i,
  output bus_evt_t evt_o
);
  logic ce_q;
  logic snap_hit, snap_we_n, snap_a2, snap_a0, snap_dq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b1;
      snap_hit  <= 1'b0;
      snap_we_n <= 1'b1;
      snap_a2   <= 1'b0;
      snap_a0   <= 1'b0;
      snap_dq   <= 1'b0;
    end else begin
      ce_q <= ce_ni;
      if (!ce_ni) begin
        snap_hit  <= hit_i;
        snap_we_n <= we_ni;
        snap_a2   <= a2_i;
        snap_a0   <= a0_i;
        snap_dq   <= dq0_i;
      end
    end
  end

  // cycle ends when chip enable goes inactive
  always_comb begin
    evt_o.valid = !ce_q && ce_ni && snap_hit;
    evt_o.wr    = mode_rom_i ? !snap_a2 : !snap_we_n;
    evt_o.bit_v = mode_rom_i ? snap_a0 : snap_dq;
  end
endmodule

// File: rtl/skp_seq.sv
module skp_seq
  import skp_pkg::*;
#(
  parameter int unsigned        SEQ_W = 64,
  parameter logic [SEQ_W-1:0]   KEY   = 64'h5CA3_3AC5_5CA3_3AC5,
  localparam int unsigned       PW    = $clog2(SEQ_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_evt_t      evt_i,
  output phase_e        phase_o,
  output logic [PW-1:0] ptr_o,
  output logic          tk_we_o,
  output logic [PW-1:0] tk_idx_o,
  output logic          tk_d_o
);
  localparam logic [PW-1:0] LAST = PW'(SEQ_W - 1);

  phase_e        phase_q;
  logic [PW-1:0] ptr_q;
  logic          at_last, key_bit;

  assign at_last = (ptr_q == LAST);
  assign key_bit = KEY[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_HUNT;
      ptr_q    <= '0;
      tk_we_o  <= 1'b0;
      tk_idx_o <= '0;
      tk_d_o   <= 1'b0;
    end else begin
      tk_we_o <= 1'b0;
      if (evt_i.valid) begin
        unique case (phase_q)
          PH_HUNT: begin
            if (!evt_i.wr) begin
              ptr_q <= '0;
            end else if (evt_i.bit_v == key_bit) begin
              if (at_last) begin
                ptr_q   <= '0;
                phase_q <= PH_XFER;
              end else begin
                ptr_q <= ptr_q + 1'b1;
              end
            end else begin
              phase_q <= PH_DEAF;
            end
          end
          PH_DEAF: begin
            if (!evt_i.wr) begin
              ptr_q   <= '0;
              phase_q <= PH_HUNT;
            end
          end
          PH_XFER: begin
            if (evt_i.wr) begin
              tk_we_o  <= 1'b1;
              tk_idx_o <= ptr_q;
              tk_d_o   <= evt_i.bit_v;
            end
            if (at_last) begin
              ptr_q   <= '0;
              phase_q <= PH_HUNT;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
          default: begin
            ptr_q   <= '0;
            phase_q <= PH_HUNT;
          end
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/skp_tx_drive.sv
module skp_tx_drive
  import skp_pkg::*;
#(
  parameter  int unsigned SEQ_W = 64,
  localparam int unsigned PW    = $clog2(SEQ_W)
) (
  input  phase_e           phase_i,
  input  logic [PW-1:0]    ptr_i,
  input  logic [SEQ_W-1:0] tk_q_i,
  input  logic             mode_rom_i,
  input  logic             ce_ni,
  input  logic             oe_ni,
  input  logic             we_ni,
  input  logic             hit_i,
  input  logic             a2_i,
  output logic             dq0_o,
  output logic             dq0_oe_o
);
  logic rd_live;

  assign rd_live  = mode_rom_i ? a2_i : we_ni;
  assign dq0_oe_o = (phase_i == PH_XFER) && !ce_ni && !oe_ni && hit_i && rd_live;
  assign dq0_o    = dq0_oe_o & tk_q_i[ptr_i];
endmodule

// File: rtl/serial_key_port.sv
module serial_key_port
  import skp_pkg::*;
#(
  parameter  int unsigned        SEQ_W       = 64,
  parameter  logic [SEQ_W-1:0]   KEY         = 64'h5CA3_3AC5_5CA3_3AC5,
  parameter  int unsigned        ADDR_W      = 16,
  parameter  logic [ADDR_W-1:0]  REGION_MASK = 16'hFFF8,
  parameter  logic [ADDR_W-1:0]  REGION_BASE = 16'h7FF8,
  localparam int unsigned        PW          = $clog2(SEQ_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_rom_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dq0_i,
  output logic              dq0_o,
  output logic              dq0_oe_o,
  input  logic [SEQ_W-1:0]  tk_q_i,
  output logic              tk_we_o,
  output logic [PW-1:0]     tk_idx_o,
  output logic              tk_d_o
);
  logic          hit;
  bus_evt_t      evt;
  phase_e        phase;
  logic [PW-1:0] ptr;

  assign hit = ((addr_i & REGION_MASK) == REGION_BASE);

  skp_bus_sampler u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_rom_i (mode_rom_i),
    .ce_ni      (ce_ni),
    .we_ni      (we_ni),
    .hit_i      (hit),
    .a2_i       (addr_i[2]),
    .a0_i       (addr_i[0]),
    .dq0_i      (dq0_i),
    .evt_o      (evt)
  );

  skp_seq #(.SEQ_W(SEQ_W), .KEY(KEY)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .phase_o  (phase),
    .ptr_o    (ptr),
    .tk_we_o  (tk_we_o),
    .tk_idx_o (tk_idx_o),
    .tk_d_o   (tk_d_o)
  );

  skp_tx_drive #(.SEQ_W(SEQ_W)) u_tx (
    .phase_i    (phase),
    .ptr_i      (ptr),
    .tk_q_i     (tk_q_i),
    .mode_rom_i (mode_rom_i),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .hit_i      (hit),
    .a2_i       (addr_i[2]),
    .dq0_o      (dq0_o),
    .dq0_oe_o   (dq0_oe_o)
  );
endmodule

// File: rtl/skp_checker.sv
module skp_checker
  import skp_pkg::*;
#(
  parameter  int unsigned SEQ_W = 64,
  localparam int unsigned PW    = $clog2(SEQ_W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          evt_valid_i,
  input logic          evt_wr_i,
  input phase_e        phase_i,
  input logic [PW-1:0] ptr_i,
  input logic          dq0_oe_i,
  input logic          tk_we_i
);
  localparam logic [PW-1:0] LAST = PW'(SEQ_W - 1);

  assert_no_drive_locked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq0_oe_i |-> phase_i == PH_XFER);

  assert_drive_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq0_oe_i |-> (!ce_ni && !oe_ni));

  assert_store_from_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_wr_i && phase_i == PH_XFER) |=> tk_we_i);

  assert_relock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && phase_i == PH_XFER && ptr_i == LAST) |=> (phase_i == PH_HUNT && ptr_i == '0));

  assert_deaf_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_DEAF && !(evt_valid_i && !evt_wr_i)) |=> phase_i == PH_DEAF);

  assert_read_restarts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !evt_wr_i && phase_i != PH_XFER) |=> (phase_i == PH_HUNT && ptr_i == '0));

  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> ($stable(phase_i) && $stable(ptr_i) && !tk_we_i));
endmodule

bind serial_key_port skp_checker #(.SEQ_W(SEQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .oe_ni       (oe_ni),
  .evt_valid_i (evt.valid),
  .evt_wr_i    (evt.wr),
  .phase_i     (phase),
  .ptr_i       (ptr),
  .dq0_oe_i    (dq0_oe_o),
  .tk_we_i     (tk_we_o)
);

// File: tb/serial_key_port_bench.sv
module serial_key_port_bench;
  localparam int unsigned      SEQ_W = 16;
  localparam int unsigned      PW    = $clog2(SEQ_W);
  localparam int unsigned      AW    = 6;
  localparam logic [SEQ_W-1:0] KEY   = 16'hA5C3;
  localparam logic [SEQ_W-1:0] TKQ   = 16'h3C96;
  localparam logic [SEQ_W-1:0] WPAT  = 16'h6B2D;
  localparam logic [AW-1:0]    MASK  = 6'b111000;
  localparam logic [AW-1:0]    BASE  = 6'b101000;
  localparam logic [AW-1:0]    OTHER = 6'b010000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_rom = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq_in = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dq_out, dq_oe, tk_we, tk_d;
  logic [PW-1:0] tk_idx;

  int tests = 0;
  int fails = 0;
  logic s_oe, s_q, s_we, s_d;
  logic [PW-1:0] s_idx;

  always #2.5 clk = ~clk;

  serial_key_port #(
    .SEQ_W(SEQ_W), .KEY(KEY), .ADDR_W(AW), .REGION_MASK(MASK), .REGION_BASE(BASE)
  ) u_serial_key_port (
    .clk_i(clk), .rst_ni(rst_ni), .mode_rom_i(mode_rom),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .addr_i(addr), .dq0_i(dq_in),
    .dq0_o(dq_out), .dq0_oe_o(dq_oe), .tk_q_i(TKQ),
    .tk_we_o(tk_we), .tk_idx_o(tk_idx), .tk_d_o(tk_d)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (mode_rom=%0d)", tag, act, exp, mode_rom);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] a, input logic wn, input logic on, input logic d);
    @(negedge clk);
    addr = a; we_n = wn; oe_n = on; dq_in = d; ce_n = 1'b0;
    @(negedge clk);
    s_oe = dq_oe; s_q = dq_out;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    s_we = tk_we; s_idx = tk_idx; s_d = tk_d;
  endtask

  // RAM: we_ni low, data on dq0, A2 set to show it is ignored. ROM: A2=0, data on A0, we/dq contrary.
  task automatic wr_bit(input logic b);
    if (mode_rom) cyc(BASE | AW'(b), 1'b1, 1'b1, ~b);
    else          cyc(BASE | 6'b000100, 1'b0, 1'b1, b);
  endtask

  task automatic rd(input logic on);
    if (mode_rom) cyc(BASE | 6'b000100, 1'b0, on, 1'b0);
    else          cyc(BASE | 6'b000001, 1'b1, on, 1'b0);
  endtask

  task automatic foreign();
    cyc(OTHER | 6'b000011, 1'b0, 1'b0, 1'b1);
    chk(!s_we && !s_oe, "R8 foreign cycle", {s_we, s_oe}, 0);
  endtask

  task automatic send_bits(input int from, input int upto, input bit mix);
    for (int i = from; i < upto; i++) begin
      wr_bit(KEY[i]);
      if (mix && (i % 3 == 1)) foreign();
    end
  endtask

  task automatic resync();
    for (int i = 0; i < SEQ_W; i++) rd(1'b1);
  endtask

  task automatic run_mode();
    string vt;
    vt = mode_rom ? "R10" : "R9";
    resync();
    rd(1'b0);
    chk(!s_oe, "R12 locked read no drive", s_oe, 0);
    // unlock with interleaved foreign traffic
    send_bits(0, SEQ_W, 1'b1);
    // full transfer pass
    for (int i = 0; i < SEQ_W; i++) begin
      if (i % 2 == 0) begin
        wr_bit(WPAT[i]);
        chk(s_we && s_idx == PW'(i) && s_d == WPAT[i] && !s_oe,
            {"R5 R2 store ", vt}, {s_we, s_idx, s_d}, {1'b1, PW'(i), WPAT[i]});
      end else if (i == 3) begin
        rd(1'b1);
        chk(!s_oe && !s_we, "R6 read with oe inactive", s_oe, 0);
      end else begin
        rd(1'b0);
        chk(s_oe && s_q == TKQ[i] && !s_we, {"R6 R2 transmit ", vt}, {s_oe, s_q}, {1'b1, TKQ[i]});
      end
      if (i % 5 == 0) foreign();
    end
    rd(1'b0);
    chk(!s_oe, "R7 relocked after full pass", s_oe, 0);
    // R11: unlock, consume one index, then resync from mid-transfer
    send_bits(0, SEQ_W, 1'b0);
    rd(1'b0);
    chk(s_oe && s_q == TKQ[0], "R2 transmit index 0", {s_oe, s_q}, {1'b1, TKQ[0]});
    resync();
    send_bits(0, SEQ_W, 1'b0);
    rd(1'b0);
    chk(s_oe && s_q == TKQ[0], "R11 resync then unlock", {s_oe, s_q}, {1'b1, TKQ[0]});
    resync();
    // R3: mismatch at every position
    for (int p = 0; p < SEQ_W; p++) begin
      send_bits(0, p, 1'b0);
      wr_bit(~KEY[p]);
      send_bits(p + 1, SEQ_W, 1'b0);
      send_bits(0, SEQ_W, 1'b0);
      rd(1'b0);
      chk(!s_oe, $sformatf("R3 mismatch at bit %0d stays locked", p), s_oe, 0);
    end
    // R4: read restarts recognition
    send_bits(0, 5, 1'b0);
    rd(1'b0);
    chk(!s_oe, "R4 read mid-key", s_oe, 0);
    send_bits(5, SEQ_W, 1'b0);
    rd(1'b0);
    chk(!s_oe, "R4 prefix discarded", s_oe, 0);
    send_bits(0, 7, 1'b0);
    rd(1'b0);
    send_bits(0, SEQ_W, 1'b0);
    rd(1'b0);
    chk(s_oe && s_q == TKQ[0], "R4 restart then full key", {s_oe, s_q}, {1'b1, TKQ[0]});
    resync();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!dq_oe && !tk_we, "R1 in reset", {dq_oe, tk_we}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!dq_oe && !tk_we && tk_idx == '0, "R1 after reset", {dq_oe, tk_we}, 0);
    // R1: key bit 0 expected immediately after reset
    send_bits(0, SEQ_W, 1'b0);
    rd(1'b0);
    chk(s_oe && s_q == TKQ[0], "R1 R2 unlock from reset", {s_oe, s_q}, {1'b1, TKQ[0]});
    mode_rom = 1'b0;
    run_mode();
    mode_rom = 1'b1;
    run_mode();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule